// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a small real-time clock that sits on a 32-bit register bus. It counts whole seconds in a 32-bit counter that advances on a one-cycle tick strobe. It compares that count against a programmable alarm value and keeps two sticky event flags, one for alarm hits and one for counter steps. Each flag has its own interrupt enable, and the two enabled flags together drive a single interrupt line. A scratch register holds a value that software uses to tell a cold start from a warm one. A hibernate register raises a latched request output.

Writes are paced by a ready bit in the control register. An accepted write clears the ready bit for a parameterised number of cycles, and any write presented during that window is dropped. The event flags are protected against read-modify-write accidents. Writing 1 to a flag bit keeps the flag as it is, and writing 0 clears it. Software can therefore rewrite the control register with the flags it read back and lose no event that is still pending.

Register offsets (byte address on `bus_addr_i`): control 0x00, seconds 0x04, alarm 0x08, scratch 0x0C, hibernate 0x10. Control bits: 0 run, 1 alarm enable, 2 alarm interrupt enable, 3 alarm flag, 4 step interrupt enable, 5 step flag, 6 ready (read-only). All other bits read 0.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the control register reads 0x40, so only the ready bit is set. Seconds, alarm and scratch read 0, and `irq_o` and `hib_req_o` are 0.
- R2: An accepted write clears the ready bit (control bit 6) for exactly BUSY_CYCLES cycles, after which it reads 1 again. Bit 6 cannot be written.
- R3: A write presented while the ready bit is 0 is ignored and leaves every register unchanged.
- R4: The seconds counter increments by one on `tick_i` only while run (control bit 0) is 1, and it wraps from 0xFFFFFFFF to 0.
- R5: A write to the seconds register in the same cycle as a tick loads the written value. No increment happens and the step flag is not set.
- R6: The step flag (control bit 5) sets on every increment of the seconds counter.
- R7: In a control write, a 1 in a flag bit (bit 3 or bit 5) leaves that flag unchanged, and a 0 clears it. A newly arising event wins over a clear in the same cycle.
- R8: The alarm flag (control bit 3) sets once when alarm enable (bit 1) is 1 and the seconds counter becomes equal to the alarm register. It does not set while alarm enable is 0, and it does not set again while the equality merely persists.
- R9: `irq_o` is 1 exactly when (alarm flag AND bit 2) OR (step flag AND bit 4).
- R10: Scratch, alarm and seconds registers read back any written 32-bit value unchanged.
- R11: Writing a value with bit 0 set to the hibernate register raises `hib_req_o`, which then stays 1 until reset. The register reads `hib_req_o` in bit 0, and writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle seconds strobe |
| bus_addr_i | input | 6 | Byte address of the register |
| bus_we_i | input | 1 | Write request |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Interrupt request |
| hib_req_o | output | 1 | Latched hibernate request |

## Verification
A corrupted seconds or alarm register would show at once on a read-back of that offset. It would also show one cycle after the next tick, as a missing or spurious alarm flag in the control word and on `irq_o`. A wrong busy counter would show within BUSY_CYCLES cycles, either as a ready bit that returns early or late, or as a write made during the window that lands in the scratch register. A flag that is lost or set twice would show at the next read of the control register and on the interrupt line, both in the cycle after the event edge.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_CTRL    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_SECS    = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_ALARM   = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SCRATCH = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_HIB     = 6'h10;

  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_AEN   = 1;
  localparam int unsigned BIT_AIE   = 2;
  localparam int unsigned BIT_AFLG  = 3;
  localparam int unsigned BIT_SIE   = 4;
  localparam int unsigned BIT_SFLG  = 5;
  localparam int unsigned BIT_READY = 6;

  typedef struct packed {
    logic run;
    logic alarm_en;
    logic alarm_ie;
    logic step_ie;
  } ctrl_cfg_t;
endpackage

// File: rtl/rtc_wr_gate.sv
module rtc_wr_gate #(
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  output logic accept_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign ready_o  = (cnt_q == '0);
  assign accept_o = wr_req_i & ready_o;

  always_comb begin
    cnt_d = cnt_q;
    if (accept_o) begin
      cnt_d = CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assert_busy_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !ready_o);
  assert_busy_counts_down_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !accept_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] secs_o,
  output logic             step_o
);
  logic [CNT_W-1:0] secs_q, secs_d;

  assign step_o = tick_i & run_i & ~load_i;

  always_comb begin
    secs_d = secs_q;
    if (load_i)      secs_d = load_val_i;
    else if (step_o) secs_d = secs_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) secs_q <= '0;
    else         secs_q <= secs_d;
  end

  assign secs_o = secs_q;

  assert_step_only_when_running_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !(tick_i && run_i)) |=> $stable(secs_o));
  assert_tick_adds_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && run_i && !load_i) |=> (secs_o == $past(secs_o) + 1'b1));
  assert_load_beats_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (secs_o == $past(load_val_i)));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] secs_i,
  output logic [CNT_W-1:0] alarm_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] alarm_q, alarm_d;
  logic             match, match_q;

  assign match = enable_i & (secs_i == alarm_q);
  assign hit_o = match & ~match_q;

  always_comb begin
    alarm_d = alarm_q;
    if (load_i) alarm_d = load_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      match_q <= 1'b0;
    end else begin
      alarm_q <= alarm_d;
      match_q <= match;
    end
  end

  assign alarm_o = alarm_q;

  assert_no_repeat_hit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> !hit_o);
endmodule

// File: rtl/rtc_event_flag.sv
module rtc_event_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic wr_i,
  input  logic wr_keep_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)                  flag_d = 1'b1;
    else if (wr_i && !wr_keep_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_flag_kept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !(wr_i && !wr_keep_i)) |=> flag_o);
  assert_event_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned BUSY_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o,
  output logic              hib_req_o
);
  localparam int unsigned CTRL_USED = BIT_READY + 1;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  // write pacing
  logic accept, ready;

  rtc_wr_gate #(.BUSY_CYCLES(BUSY_CYCLES)) i_wr_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .wr_req_i (bus_we_i),
    .accept_o (accept),
    .ready_o  (ready)
  );

  logic wr_ctrl, wr_secs, wr_alarm, wr_scratch, wr_hib;
  assign wr_ctrl    = accept & (bus_addr_i == OFS_CTRL);
  assign wr_secs    = accept & (bus_addr_i == OFS_SECS);
  assign wr_alarm   = accept & (bus_addr_i == OFS_ALARM);
  assign wr_scratch = accept & (bus_addr_i == OFS_SCRATCH);
  assign wr_hib     = accept & (bus_addr_i == OFS_HIB);

  // configuration, scratch and hibernate registers
  ctrl_cfg_t         cfg_q, cfg_d;
  logic [DATA_W-1:0] scratch_q, scratch_d;
  logic              hib_q, hib_d;

  always_comb begin
    cfg_d     = cfg_q;
    scratch_d = scratch_q;
    hib_d     = hib_q;
    if (wr_ctrl) begin
      cfg_d.run      = bus_wdata_i[BIT_RUN];
      cfg_d.alarm_en = bus_wdata_i[BIT_AEN];
      cfg_d.alarm_ie = bus_wdata_i[BIT_AIE];
      cfg_d.step_ie  = bus_wdata_i[BIT_SIE];
    end
    if (wr_scratch) scratch_d = bus_wdata_i;
    if (wr_hib && bus_wdata_i[0]) hib_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      scratch_q <= '0;
      hib_q     <= 1'b0;
    end else begin
      cfg_q     <= cfg_d;
      scratch_q <= scratch_d;
      hib_q     <= hib_d;
    end
  end

  // seconds counter and alarm compare
  logic [DATA_W-1:0] secs, alarm;
  logic              step, hit;

  rtc_sec_counter #(.CNT_W(DATA_W)) i_sec_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_i      (cfg_q.run),
    .tick_i     (tick_i),
    .load_i     (wr_secs),
    .load_val_i (bus_wdata_i),
    .secs_o     (secs),
    .step_o     (step)
  );

  rtc_alarm_unit #(.CNT_W(DATA_W)) i_alarm_unit (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .enable_i   (cfg_q.alarm_en),
    .load_i     (wr_alarm),
    .load_val_i (bus_wdata_i),
    .secs_i     (secs),
    .alarm_o    (alarm),
    .hit_o      (hit)
  );

  // two sticky event flags: index 0 alarm, index 1 step
  logic [1:0] ev_set, ev_keep, ev_flag;
  assign ev_set  = {step, hit};
  assign ev_keep = {bus_wdata_i[BIT_SFLG], bus_wdata_i[BIT_AFLG]};

  for (genvar g = 0; g < 2; g++) begin : g_flag
    rtc_event_flag i_flag (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .set_i     (ev_set[g]),
      .wr_i      (wr_ctrl),
      .wr_keep_i (ev_keep[g]),
      .flag_o    (ev_flag[g])
    );
  end

  // read path and outputs
  logic [CTRL_USED-1:0] ctrl_word;
  always_comb begin
    ctrl_word            = '0;
    ctrl_word[BIT_RUN]   = cfg_q.run;
    ctrl_word[BIT_AEN]   = cfg_q.alarm_en;
    ctrl_word[BIT_AIE]   = cfg_q.alarm_ie;
    ctrl_word[BIT_AFLG]  = ev_flag[0];
    ctrl_word[BIT_SIE]   = cfg_q.step_ie;
    ctrl_word[BIT_SFLG]  = ev_flag[1];
    ctrl_word[BIT_READY] = ready;
  end

  always_comb begin
    unique case (bus_addr_i)
      OFS_CTRL:    bus_rdata_o = DATA_W'(ctrl_word);
      OFS_SECS:    bus_rdata_o = secs;
      OFS_ALARM:   bus_rdata_o = alarm;
      OFS_SCRATCH: bus_rdata_o = scratch_q;
      OFS_HIB:     bus_rdata_o = DATA_W'(hib_q);
      default:     bus_rdata_o = '0;
    endcase
  end

  assign irq_o     = (ev_flag[0] & cfg_q.alarm_ie) | (ev_flag[1] & cfg_q.step_ie);
  assign hib_req_o = hib_q;

  assert_busy_write_dropped_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (bus_we_i && !ready && bus_addr_i == OFS_SCRATCH) |=> $stable(scratch_q));
  assert_alarm_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(ev_flag[0]) |-> $past(cfg_q.alarm_en));
  assert_hib_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    hib_req_o |=> hib_req_o);
endmodule

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
  localparam int unsigned BUSY = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [5:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, hib;

  int checks = 0;
  int bad    = 0;

  always #4 clk = ~clk;

  rtc_sec_alarm #(.DATA_W(32), .BUSY_CYCLES(BUSY)) i_rtc_sec_alarm (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tick_i      (tick),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .hib_req_o   (hib)
  );

  localparam logic [5:0] A_CTRL = 6'h00, A_SECS = 6'h04, A_ALRM = 6'h08,
                         A_SCR = 6'h0C, A_HIB = 6'h10;

  // {address, write data, expected read-back}
  localparam int NVEC = 7;
  localparam logic [71:0] VEC [NVEC] = '{
    {2'b0, 6'h0C, 32'hA5A5_5A5A, 32'hA5A5_5A5A},
    {2'b0, 6'h0C, 32'h0F0F_F0F0, 32'h0F0F_F0F0},
    {2'b0, 6'h08, 32'h1234_5678, 32'h1234_5678},
    {2'b0, 6'h04, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {2'b0, 6'h10, 32'h0000_0000, 32'h0000_0000},
    {2'b0, 6'h00, 32'h0000_0015, 32'h0000_0055},
    {2'b0, 6'h00, 32'h0000_0040, 32'h0000_0040}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_raw(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic write_reg(input logic [5:0] a, input logic [31:0] d);
    write_raw(a, d);
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic read_reg(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic pulse_tick;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; tick = 1'b0; addr = '0; we = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    read_reg(A_CTRL, v);    check("R1 ctrl", v, 32'h40);
    read_reg(A_SECS, v);    check("R1 secs", v, 0);
    read_reg(A_ALRM, v);    check("R1 alarm", v, 0);
    read_reg(A_SCR, v);     check("R1 scratch", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 hib", {31'b0, hib}, 0);

    // R10 / R2 table walk
    for (int i = 0; i < NVEC; i++) begin
      write_reg(VEC[i][69:64], VEC[i][63:32]);
      read_reg(VEC[i][69:64], v);
      check($sformatf("R10 vector %0d", i), v, VEC[i][31:0]);
    end
    write_reg(A_CTRL, 32'h0);

    // R2 ready window
    write_raw(A_SCR, 32'h1);
    read_reg(A_CTRL, v);     check("R2 busy right after write", v, 32'h00);
    repeat (BUSY - 1) @(negedge clk);
    read_reg(A_CTRL, v);     check("R2 busy at last cycle", v, 32'h00);
    @(negedge clk);
    read_reg(A_CTRL, v);     check("R2 ready again", v, 32'h40);

    // R3 write during busy dropped
    write_raw(A_SCR, 32'h2222);
    write_raw(A_SCR, 32'h3333);
    repeat (BUSY) @(negedge clk);
    read_reg(A_SCR, v);      check("R3 busy write ignored", v, 32'h2222);

    // R4 counting
    write_reg(A_SECS, 32'd5);
    pulse_tick();
    read_reg(A_SECS, v);     check("R4 no step while stopped", v, 32'd5);
    write_reg(A_CTRL, 32'h01);
    pulse_tick();
    read_reg(A_SECS, v);     check("R4 step while running", v, 32'd6);
    write_reg(A_SECS, 32'hFFFF_FFFF);
    pulse_tick();
    read_reg(A_SECS, v);     check("R4 wrap", v, 32'h0);
    read_reg(A_CTRL, v);     check("R6 step flag set", v, 32'h61);

    // R7 keep / clear
    write_reg(A_CTRL, 32'h21);
    read_reg(A_CTRL, v);     check("R7 write 1 keeps", v, 32'h61);
    write_reg(A_CTRL, 32'h01);
    read_reg(A_CTRL, v);     check("R7 write 0 clears", v, 32'h41);
    pulse_tick();
    read_reg(A_CTRL, v);     check("R6 step flag again", v, 32'h61);
    write_reg(A_CTRL, 32'h01);

    // R5 write beats tick
    @(negedge clk);
    addr = A_SECS; wdata = 32'h100; we = 1'b1; tick = 1'b1;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    repeat (BUSY) @(negedge clk);
    read_reg(A_SECS, v);     check("R5 load wins", v, 32'h100);
    read_reg(A_CTRL, v);     check("R5 no step flag", v, 32'h41);

    // R8 alarm
    write_reg(A_ALRM, 32'h101);
    pulse_tick();
    read_reg(A_CTRL, v);     check("R8 no alarm while disabled", v, 32'h61);
    write_reg(A_CTRL, 32'h07);
    read_reg(A_CTRL, v);     check("R8 alarm on enable at match", v, 32'h4F);
    check("R9 alarm irq", {31'b0, irq}, 1);
    write_reg(A_CTRL, 32'h07);
    read_reg(A_CTRL, v);     check("R8 no re-set while match holds", v, 32'h47);
    check("R9 irq drops", {31'b0, irq}, 0);
    write_reg(A_ALRM, 32'h103);
    pulse_tick();
    read_reg(A_CTRL, v);     check("R8 no alarm before match", v, 32'h67);
    pulse_tick();
    read_reg(A_CTRL, v);     check("R8 alarm at match", v, 32'h6F);
    check("R9 irq from alarm", {31'b0, irq}, 1);
    write_reg(A_CTRL, 32'h29);
    read_reg(A_CTRL, v);     check("R9 ctrl after ie off", v, 32'h69);
    check("R9 irq masked", {31'b0, irq}, 0);
    write_reg(A_CTRL, 32'h11);
    check("R9 no irq without flags", {31'b0, irq}, 0);
    pulse_tick();
    check("R9 step irq", {31'b0, irq}, 1);
    write_reg(A_CTRL, 32'h21);
    check("R9 step irq masked", {31'b0, irq}, 0);

    // R11 hibernate
    write_reg(A_HIB, 32'h0);
    check("R11 zero write no request", {31'b0, hib}, 0);
    write_reg(A_HIB, 32'h1);
    check("R11 request raised", {31'b0, hib}, 1);
    write_reg(A_HIB, 32'h0);
    read_reg(A_HIB, v);      check("R11 request held", v, 32'h1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule